// File: doc/BRIEF.md
# Interrupt Control Register File with Write Legalization

This block holds one 8-bit control byte per interrupt for a core-local vectored interrupt controller. It also derives the privilege mode of each interrupt from that byte. Each byte keeps only `CTL_BITS` stored bits, and these sit at the top of the byte. The bits below them always read as ones. Every write is legalized before it is stored. The value is first rounded up onto the grid of values the implemented bits can hold. It is then clamped into the value band that belongs to the writer's privilege. An illegal value can therefore never reach the register.

No separate mode bit is stored. The interrupt counts as machine mode when its control byte lies at or above `M_LO`, and as supervisor mode below that. When `NMODE_BITS` is 0, only one privilege mode exists and every interrupt is machine mode. Software reaches the file through a single port made of index, write enable, write data and the requester's privilege. Read data is combinational. The full set of control bytes and mode bits is exported in parallel to the arbitration logic. All parameters are fixed for the life of the block.

Top module: `intctl_warl_file`

## Requirements
- R1: Only the top `CTL_BITS` bits (0 to 8) of each control byte are stored. The lower `8-CTL_BITS` bits always read as 1. With 2 bits a byte holds only 63, 127, 191 or 255, and with 0 bits it is always 255.
- R2: With `NMODE_BITS`=1, `mode_o[i]` is 1 (machine) exactly when control byte i is at least `M_LO`, and 0 (supervisor) otherwise. The default `M_LO`=240 means machine exactly when bits 7:4 are all ones.
- R3: With `NMODE_BITS`=0, every `mode_o` bit is 1 and the legal write band is 0..255.
- R4: `priv_i`=1 denotes a machine requester, whose band is `M_LO`..255. `priv_i`=0 denotes a supervisor requester, whose band is 0..`M_LO-1`. A written value first has its unimplemented bits forced to 1. A result below the band is then stored as the smallest value of the band that the implemented bits can hold, and a result above the band as the largest such value.
- R5: A supervisor requester addressing a machine-mode interrupt reads 0, and its write changes no register.
- R6: A permitted read returns the current byte in the same cycle, also during a write. A write becomes visible on the next cycle. Without a write, no byte changes.
- R7: On reset, an interrupt whose bit is set in `S_RESET_MASK` (and `NMODE_BITS`=1) takes the largest legal supervisor value, which is 239 by default. Every other interrupt takes 255.
- R8: An index at or above `NUM_IRQ` reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | IDX_W | Interrupt index for read and write |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Requested control byte |
| priv_i | input | 1 | Requester privilege: 1 machine, 0 supervisor |
| rdata_o | output | 8 | Read data for `idx_i` |
| ctl_o | output | NUM_IRQ*8 | Effective control bytes, interrupt i at bits 8i+7:8i |
| mode_o | output | NUM_IRQ | Derived mode per interrupt: 1 machine, 0 supervisor |

## Verification
The access check and the legalizing clamp act in the same cycle. The access decision uses the mode the target has now, while the clamp decides the mode it will have next. The bench drives a full sweep of all 256 byte values from a supervisor requester into supervisor-owned interrupts, including values inside the machine band. Each write must pass the check, and the next cycle must show the clamped byte with the mode still supervisor. The bench then turns those interrupts into machine mode with machine writes and repeats supervisor writes. Those writes must now be refused, and the bytes and modes observed on the ports must stay unchanged.

// File: rtl/intctl_pkg.sv
package intctl_pkg;

  typedef enum logic {
    PRIV_S = 1'b0,
    PRIV_M = 1'b1
  } priv_e;

  // ones in every unimplemented low bit
  function automatic logic [7:0] low_ones(int unsigned bits);
    return 8'((1 << (8 - bits)) - 1);
  endfunction

  // smallest representable value not below lo
  function automatic logic [7:0] legal_ceil(logic [7:0] lo, logic [7:0] low);
    return lo | low;
  endfunction

  // largest representable value not above hi
  function automatic logic [7:0] legal_floor(logic [7:0] hi, logic [7:0] low);
    logic [8:0] x;
    x = {1'b0, (hi & ~low) | low};
    if (x > {1'b0, hi}) x = x - ({1'b0, low} + 9'd1);
    return x[7:0];
  endfunction

endpackage

// File: rtl/intctl_legalizer.sv
module intctl_legalizer
  import intctl_pkg::*;
#(
  parameter int unsigned CTL_BITS   = 5,
  parameter int unsigned NMODE_BITS = 1,
  parameter logic [7:0]  M_LO       = 8'd240
) (
  input  logic [7:0] wdata_i,
  input  priv_e      priv_i,
  output logic [7:0] legal_o
);

  localparam logic [7:0] LOW    = low_ones(CTL_BITS);
  localparam logic [7:0] M_LO_L = legal_ceil(M_LO, LOW);
  localparam logic [7:0] M_HI_L = legal_floor(8'hFF, LOW);
  localparam logic [7:0] S_LO_L = legal_ceil(8'h00, LOW);
  localparam logic [7:0] S_HI_L = legal_floor(M_LO - 8'd1, LOW);

  logic [7:0] band_lo, band_hi, masked;

  always_comb begin
    if (NMODE_BITS == 0) begin
      band_lo = S_LO_L;
      band_hi = M_HI_L;
    end else if (priv_i == PRIV_M) begin
      band_lo = M_LO_L;
      band_hi = M_HI_L;
    end else begin
      band_lo = S_LO_L;
      band_hi = S_HI_L;
    end
  end

  assign masked = wdata_i | LOW;

  always_comb begin
    if (masked < band_lo)      legal_o = band_lo;
    else if (masked > band_hi) legal_o = band_hi;
    else                       legal_o = masked;
  end

endmodule

// File: rtl/intctl_cell.sv
module intctl_cell #(
  parameter int unsigned CTL_BITS = 5,
  parameter logic [7:0]  RST_VAL  = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctl_o
);

  if (CTL_BITS == 0) begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, we_i, wdata_i};
    assign ctl_o = 8'hFF;
  end else begin : g_bits
    logic [CTL_BITS-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= RST_VAL[7 -: CTL_BITS];
      else if (we_i) q <= wdata_i[7 -: CTL_BITS];
    end

    if (CTL_BITS >= 8) begin : g_full
      assign ctl_o = q;
    end else begin : g_pad
      logic unused_lo;
      assign unused_lo = ^wdata_i[7-CTL_BITS:0];
      assign ctl_o = {q, {(8 - CTL_BITS){1'b1}}};
    end
  end

endmodule

// File: rtl/intctl_warl_file.sv
module intctl_warl_file
  import intctl_pkg::*;
#(
  parameter int unsigned NUM_IRQ      = 6,
  parameter int unsigned CTL_BITS     = 5,
  parameter int unsigned NMODE_BITS   = 1,
  parameter logic [7:0]  M_LO         = 8'd240,
  parameter logic [31:0] S_RESET_MASK = 32'h0000_000C,
  localparam int unsigned IDX_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 we_i,
  input  logic [7:0]           wdata_i,
  input  logic                 priv_i,
  output logic [7:0]           rdata_o,
  output logic [NUM_IRQ*8-1:0] ctl_o,
  output logic [NUM_IRQ-1:0]   mode_o
);

  localparam logic [7:0] LOW    = low_ones(CTL_BITS);
  localparam logic [7:0] S_HI_L = legal_floor(M_LO - 8'd1, LOW);

  logic             idx_ok, sel_mode, access_ok;
  logic [7:0]       legal_w;
  logic [7:0]       ctl_q [NUM_IRQ];
  logic [NUM_IRQ-1:0] cell_we;

  assign idx_ok    = 32'(idx_i) < NUM_IRQ;
  assign sel_mode  = idx_ok && mode_o[idx_i];
  // supervisor may touch only supervisor-owned entries
  assign access_ok = idx_ok && (priv_i || !sel_mode);
  assign rdata_o   = access_ok ? ctl_q[idx_i] : 8'h00;

  intctl_legalizer #(
    .CTL_BITS  (CTL_BITS),
    .NMODE_BITS(NMODE_BITS),
    .M_LO      (M_LO)
  ) u_legal (
    .wdata_i(wdata_i),
    .priv_i (priv_e'(priv_i)),
    .legal_o(legal_w)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam logic [7:0] RV =
      (S_RESET_MASK[i] && NMODE_BITS != 0) ? S_HI_L : 8'hFF;

    assign cell_we[i] = we_i && access_ok && (32'(idx_i) == i);

    intctl_cell #(
      .CTL_BITS(CTL_BITS),
      .RST_VAL (RV)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cell_we[i]),
      .wdata_i(legal_w),
      .ctl_o  (ctl_q[i])
    );

    assign ctl_o[i*8 +: 8] = ctl_q[i];

    if (NMODE_BITS == 0) begin : g_single
      assign mode_o[i] = 1'b1;
    end else begin : g_split
      assign mode_o[i] = (ctl_q[i] >= M_LO);
    end
  end

endmodule

// File: rtl/intctl_warl_checker.sv
module intctl_warl_checker #(
  parameter int unsigned NUM_IRQ    = 6,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned NMODE_BITS = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [IDX_W-1:0]     idx_i,
  input logic                 we_i,
  input logic                 priv_i,
  input logic [7:0]           rdata_o,
  input logic [NUM_IRQ*8-1:0] ctl_o,
  input logic [NUM_IRQ-1:0]   mode_o
);

  logic idx_ok, sel_mode;
  assign idx_ok   = 32'(idx_i) < NUM_IRQ;
  assign sel_mode = idx_ok && mode_o[idx_i];

  assert_sup_read_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i && sel_mode) |-> rdata_o == 8'h00);

  assert_sup_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i && sel_mode) |=> ($stable(ctl_o) && $stable(mode_o)));

  assert_sup_write_keeps_sup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NMODE_BITS != 0 && we_i && !priv_i && idx_ok && !sel_mode) |=> !mode_o[$past(idx_i)]);

  assert_mach_write_is_mach_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i && idx_ok) |=> mode_o[$past(idx_i)]);

  assert_bad_idx_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_ok |-> rdata_o == 8'h00);

  assert_bad_idx_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !idx_ok) |=> $stable(ctl_o));

  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_o));

endmodule

bind intctl_warl_file intctl_warl_checker #(
  .NUM_IRQ   (NUM_IRQ),
  .IDX_W     (IDX_W),
  .NMODE_BITS(NMODE_BITS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .idx_i  (idx_i),
  .we_i   (we_i),
  .priv_i (priv_i),
  .rdata_o(rdata_o),
  .ctl_o  (ctl_o),
  .mode_o (mode_o)
);

// File: tb/sim_intctl_warl_file.sv
`timescale 1ns/1ps
module sim_intctl_warl_file;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] wd = '0;
  logic       priv = 1'b1;
  logic [2:0] idx0 = '0;
  logic [1:0] idx1 = '0;
  logic [0:0] idx2 = '0;
  logic       we0 = 1'b0, we1 = 1'b0, we2 = 1'b0;
  logic [7:0] rd0, rd1, rd2;
  logic [47:0] ctl0;
  logic [31:0] ctl1;
  logic [15:0] ctl2;
  logic [5:0] mode0;
  logic [3:0] mode1;
  logic [1:0] mode2;

  int checks = 0;
  int bad = 0;
  int exp0 [6];
  int exp1 [4];

  // 5 bits, two modes, irq 2 and 3 start supervisor
  intctl_warl_file #(.NUM_IRQ(6), .CTL_BITS(5), .NMODE_BITS(1), .M_LO(8'd240),
    .S_RESET_MASK(32'h0C)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx0), .we_i(we0), .wdata_i(wd),
    .priv_i(priv), .rdata_o(rd0), .ctl_o(ctl0), .mode_o(mode0));

  // 2 bits, single mode
  intctl_warl_file #(.NUM_IRQ(4), .CTL_BITS(2), .NMODE_BITS(0), .M_LO(8'd240),
    .S_RESET_MASK(32'h0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx1), .we_i(we1), .wdata_i(wd),
    .priv_i(priv), .rdata_o(rd1), .ctl_o(ctl1), .mode_o(mode1));

  // no implemented bits
  intctl_warl_file #(.NUM_IRQ(2), .CTL_BITS(0), .NMODE_BITS(0), .M_LO(8'd240),
    .S_RESET_MASK(32'h0)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx2), .we_i(we2), .wdata_i(wd),
    .priv_i(priv), .rdata_o(rd2), .ctl_o(ctl2), .mode_o(mode2));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_legal(int v, bit p, int bits, int nmode, int mlo);
    int low, m, lo, hi, lo_l, hi_l;
    low = (1 << (8 - bits)) - 1;
    m = v | low;
    if (nmode == 0) begin lo = 0; hi = 255; end
    else if (p) begin lo = mlo; hi = 255; end
    else begin lo = 0; hi = mlo - 1; end
    lo_l = 255;
    for (int x = 255; x >= lo; x--) if ((x & low) == low) lo_l = x;
    hi_l = 0;
    for (int x = 0; x <= hi; x++) if ((x & low) == low) hi_l = x;
    if (m < lo_l) return lo_l;
    if (m > hi_l) return hi_l;
    return m;
  endfunction

  task automatic check_all0(string req);
    for (int i = 0; i < 6; i++) begin
      check(req, int'(ctl0[i*8 +: 8]), exp0[i]);
      check("R2", int'(mode0[i]), (exp0[i] >= 240) ? 1 : 0);
    end
  endtask

  task automatic check_all1(string req);
    for (int i = 0; i < 4; i++) begin
      check(req, int'(ctl1[i*8 +: 8]), exp1[i]);
      check("R3", int'(mode1[i]), 1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) exp0[i] = (i == 2 || i == 3) ? 239 : 255;
    for (int i = 0; i < 4; i++) exp1[i] = 255;
    @(negedge clk);
  endtask

  task automatic wr0(int i, int v, bit p);
    bit allowed;
    string tag;
    @(negedge clk);
    idx0 = 3'(i); wd = 8'(v); priv = p; we0 = 1'b1;
    allowed = (i < 6) && (p || !(exp0[i] >= 240));
    tag = (i >= 6) ? "R8" : (!allowed ? "R5" : "R6");
    #1;
    check(tag, int'(rd0), allowed ? exp0[i] : 0);
    @(posedge clk);
    #1 we0 = 1'b0;
    if (allowed) exp0[i] = exp_legal(v, p, 5, 1, 240);
    @(negedge clk);
    check_all0((i >= 6) ? "R8" : (allowed ? "R4" : "R5"));
  endtask

  task automatic wr1(int i, int v, bit p);
    @(negedge clk);
    idx1 = 2'(i); wd = 8'(v); priv = p; we1 = 1'b1;
    #1;
    check(p ? "R6" : "R5", int'(rd1), p ? exp1[i] : 0);
    @(posedge clk);
    #1 we1 = 1'b0;
    if (p) exp1[i] = exp_legal(v, p, 2, 0, 240);
    @(negedge clk);
    check_all1(p ? "R1" : "R5");
  endtask

  task automatic wr2(int i, int v);
    @(negedge clk);
    idx2 = 1'(i); wd = 8'(v); priv = 1'b1; we2 = 1'b1;
    @(posedge clk);
    #1 we2 = 1'b0;
    @(negedge clk);
    check("R1", int'(ctl2[i*8 +: 8]), 255);
    check("R1", int'(rd2), 255);
    check("R3", int'(mode2), 3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    do_reset();
    // reset values (R7)
    check_all0("R7");
    check_all1("R7");
    check("R7", int'(ctl2), 16'hFFFF);

    // supervisor sweep into supervisor-owned entries (R4)
    for (int v = 0; v < 256; v++) wr0(2, v, 1'b0);
    for (int v = 255; v >= 0; v--) wr0(3, v, 1'b0);
    // supervisor against machine entries (R5)
    for (int v = 0; v < 256; v += 17) wr0(0, v, 1'b0);
    for (int v = 0; v < 256; v += 29) wr0(5, v, 1'b0);
    // machine sweep on every entry (R4, R2)
    for (int i = 0; i < 6; i++)
      for (int v = 0; v < 256; v++) wr0(i, v, 1'b1);
    // entries 2,3 now machine: supervisor blocked (R5)
    for (int v = 0; v < 256; v += 13) wr0(2, v, 1'b0);
    // out-of-range indices (R8)
    for (int v = 0; v < 256; v += 51) begin
      wr0(6, v, 1'b1);
      wr0(7, v, 1'b0);
    end

    // reset again, state restored (R7)
    do_reset();
    check_all0("R7");
    wr0(3, 8'd100, 1'b0);

    // single-mode, 2-bit file (R1, R3)
    for (int i = 0; i < 4; i++)
      for (int v = 0; v < 256; v++) wr1(i, v, 1'b1);
    for (int v = 0; v < 256; v += 37) wr1(1, v, 1'b0);

    // zero-bit file (R1)
    for (int v = 0; v < 256; v += 5) wr2(v % 2, v);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule